// File: doc/BRIEF.md
# Fractional Bit-Clock Enable Generator

This block derives a timing strobe from the system clock for a serial bus controller. The strobe runs at sixteen times the wanted bit rate, so the protocol engine gets sixteen equal timing ticks in each bit. Two stages produce the rate. A small integer divider first thins the system clock into a prescaled tick. A phase accumulator then adds a programmable step on every prescaled tick. Each time that addition overflows, the block raises the enable for one system clock. The strobe rate is therefore clk / P * step / 256, where P is the divide value from 1 to 8. This gives a much finer rate choice than a plain integer divider.

Software or a configuration sequencer loads all settings at once as a single packed word. The word also carries a glitch-filter setting. This block does not use that setting; it only holds it and presents it to the neighbouring input filter. Each configuration write starts the divider and the accumulator from zero, so the strobe phase after a write is deterministic.

Top module: `frac_bitclk_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `en16_o` is 0 and `flt_o` is 0. Reset loads an all-zero configuration (divide by 1, step 0), so no enable appears afterwards until a configuration write.
- R2: The configuration word has the field `cfg_word[2:0]` = divide value minus one (P = field + 1). After a write edge, call the following clock period cycle 0. Then `tick_o` is high exactly in the cycles c for which (c+1) is a multiple of P.
- R3: The configuration word has the field `cfg_word[10:3]` = step. Over cycles 0 to C-1 after a write, the number of enable cycles equals floor(floor((C-1)/P) * step / 256).
- R4: `en16_o` is high for one system clock in the cycle that directly follows each prescaled tick whose 8-bit accumulator addition carries out. The first enable after a write is therefore in cycle ceil(256/step) * P.
- R5: A step of zero produces no enable at all, for any divide value.
- R6: With P = 1 and step = 255, `en16_o` is low in cycles 0 and 1, high in every cycle 2 to 256, and low in cycle 257.
- R7: A configuration write clears the divider count, the accumulator and any pending enable on the same edge. `en16_o` is 0 in cycle 0, and the strobe pattern that follows matches a fresh start, whatever phase the block was in before the write.
- R8: The configuration word has the field `cfg_word[18:11]` = filter setting. It appears unchanged on `flt_o` from cycle 0 after the write and holds until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Load strobe for `cfg_word`, one cycle |
| cfg_word | input | 19 | Packed configuration: filter [18:11], step [10:3], divide-minus-one [2:0] |
| tick_o | output | 1 | Prescaled tick, high one cycle every P cycles |
| en16_o | output | 1 | Enable strobe at sixteen times the bit rate |
| flt_o | output | 8 | Stored filter setting for the neighbouring filter |

## Verification
A write lands on one edge. The filter value and a cleared enable are both visible in cycle 0, the period right after that edge. `tick_o` decodes the divider count without a further register, so the n-th tick is due in cycle n*P-1. `en16_o` is registered and shows a carrying tick one cycle later, in cycle n*P. The bench drives every input and samples every output on the falling clock edge. It numbers cycles from the write edge, and it derives the expected tick positions, enable counts and first-enable cycle from these offsets alone. Directed runs check the exact cycles around the first carry, the 255-step edge and a write made in mid-phase.

// File: rtl/frac_bitclk_pkg.sv
package frac_bitclk_pkg;

   // default field widths of the packed configuration word
   localparam int unsigned DEF_DIV_W  = 3;
   localparam int unsigned DEF_STEP_W = 8;
   localparam int unsigned DEF_FLT_W  = 8;

   // width of the whole packed word for a given set of field widths
   function automatic int unsigned cfg_width(input int unsigned div_w,
                                             input int unsigned step_w,
                                             input int unsigned flt_w);
      return div_w + step_w + flt_w;
   endfunction

endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg
   import frac_bitclk_pkg::*;
#(
   parameter int unsigned DIV_W  = DEF_DIV_W,
   parameter int unsigned STEP_W = DEF_STEP_W,
   parameter int unsigned FLT_W  = DEF_FLT_W,
   localparam int unsigned CFG_W = cfg_width(DIV_W, STEP_W, FLT_W),
   localparam int unsigned STEP_LO = DIV_W,
   localparam int unsigned FLT_LO  = DIV_W + STEP_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic [CFG_W-1:0]  word_i,
   output logic [DIV_W-1:0]  div_m1_o,
   output logic [STEP_W-1:0] step_o,
   output logic [FLT_W-1:0]  flt_o
);

   logic [DIV_W-1:0]  div_q;
   logic [STEP_W-1:0] step_q;
   logic [FLT_W-1:0]  flt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q  <= '0;
         step_q <= '0;
         flt_q  <= '0;
      end else if (wr_i) begin
         div_q  <= word_i[DIV_W-1:0];
         step_q <= word_i[STEP_LO +: STEP_W];
         flt_q  <= word_i[FLT_LO +: FLT_W];
      end
   end

   assign div_m1_o = div_q;
   assign step_o   = step_q;
   assign flt_o    = flt_q;

   AST_FLT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_i |=> $stable(flt_q)); // R8
   AST_FLT_LOAD: assert property (@(posedge clk) disable iff (rst)
      wr_i |=> (flt_q == $past(word_i[FLT_LO +: FLT_W]))); // R8

endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
   parameter int unsigned DIV_W  = 3,
   parameter bit          BYPASS = 1'b0
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_m1_i,
   output logic             tick_o
);

   generate
      if (BYPASS) begin : g_bypass
         // every system clock is a prescaled tick; the divide field is unused
         assign tick_o = 1'b1;
      end else begin : g_count
         logic [DIV_W-1:0] cnt_q;
         logic             wrap;

         assign wrap = (cnt_q == div_m1_i);

         always_ff @(posedge clk) begin
            if (rst || clr_i)
               cnt_q <= '0;
            else if (wrap)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + DIV_W'(1);
         end

         assign tick_o = wrap;

         AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= div_m1_i); // R2
         AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
            (tick_o && (div_m1_i != '0) && !clr_i) |=> !tick_o); // R2
      end
   endgenerate

endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
   parameter int unsigned STEP_W = 8
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [STEP_W-1:0] step_i,
   output logic              en_o
);

   logic [STEP_W-1:0] acc_q;
   logic [STEP_W:0]   sum;
   logic              en_q;

   assign sum = {1'b0, acc_q} + {1'b0, step_i};

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         acc_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (tick_i)
            acc_q <= sum[STEP_W-1:0];
         en_q <= tick_i & sum[STEP_W];
      end
   end

   assign en_o = en_q;

   AST_EN_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
      en_q |-> $past(tick_i)); // R4
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!tick_i && !clr_i) |=> $stable(acc_q)); // R3
   AST_ZERO_STEP_SILENT: assert property (@(posedge clk) disable iff (rst)
      (step_i == '0) |-> !en_q); // R5
   AST_CLR_KILLS_EN: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (!en_q && (acc_q == '0))); // R7

endmodule

// File: rtl/frac_bitclk_gen.sv
module frac_bitclk_gen
   import frac_bitclk_pkg::*;
#(
   parameter int unsigned DIV_W      = DEF_DIV_W,
   parameter int unsigned STEP_W     = DEF_STEP_W,
   parameter int unsigned FLT_W      = DEF_FLT_W,
   parameter bit          BYPASS_DIV = 1'b0,
   localparam int unsigned CFG_W     = cfg_width(DIV_W, STEP_W, FLT_W)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_word,
   output logic             tick_o,
   output logic             en16_o,
   output logic [FLT_W-1:0] flt_o
);

   generate
      if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
         $error("frac_bitclk_gen: DIV_W must be 1..4");
      end
      if (STEP_W < 2 || STEP_W > 16) begin : g_bad_step
         $error("frac_bitclk_gen: STEP_W must be 2..16");
      end
      if (FLT_W < 1) begin : g_bad_flt
         $error("frac_bitclk_gen: FLT_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0]  div_m1;
   logic [STEP_W-1:0] step;
   logic              tick;

   fbg_cfg_reg #(
      .DIV_W  (DIV_W),
      .STEP_W (STEP_W),
      .FLT_W  (FLT_W)
   ) u_cfg (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (cfg_wr),
      .word_i   (cfg_word),
      .div_m1_o (div_m1),
      .step_o   (step),
      .flt_o    (flt_o)
   );

   fbg_prescaler #(
      .DIV_W  (DIV_W),
      .BYPASS (BYPASS_DIV)
   ) u_div (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (cfg_wr),
      .div_m1_i (div_m1),
      .tick_o   (tick)
   );

   fbg_phase_acc #(
      .STEP_W (STEP_W)
   ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (cfg_wr),
      .tick_i (tick),
      .step_i (step),
      .en_o   (en16_o)
   );

   assign tick_o = tick;

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!en16_o && (flt_o == '0))); // R1

endmodule

// File: tb/frac_bitclk_gen_test.sv
module frac_bitclk_gen_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [18:0] cfg_word = '0;
   logic        tick_o;
   logic        en16_o;
   logic [7:0]  flt_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   frac_bitclk_gen uut (
      .clk      (clk),
      .rst      (rst),
      .cfg_wr   (cfg_wr),
      .cfg_word (cfg_word),
      .tick_o   (tick_o),
      .en16_o   (en16_o),
      .flt_o    (flt_o)
   );

   typedef struct packed {
      logic [2:0]  dm1;
      logic [7:0]  step;
      logic [7:0]  flt;
      logic [15:0] cyc;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{3'd0, 8'd16,  8'h11, 16'd512},
      '{3'd1, 8'd128, 8'h22, 16'd200},
      '{3'd7, 8'd64,  8'hA5, 16'd400},
      '{3'd2, 8'd255, 8'h00, 16'd300},
      '{3'd4, 8'd3,   8'hFF, 16'd2000},
      '{3'd0, 8'd0,   8'h5A, 16'd300},
      '{3'd5, 8'd1,   8'h01, 16'd3000}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive a write; returns positioned in cycle 0 after the write edge
   task automatic write_cfg(input logic [2:0] dm1, input logic [7:0] step,
                            input logic [7:0] flt);
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_word = {flt, step, dm1};
      @(negedge clk);
      cfg_wr   = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(en16_o == 1'b0, "R1 en during reset", int'(en16_o), 0);
      check(flt_o == 8'h00, "R1 flt during reset", int'(flt_o), 0);
      rst = 1'b0;
      @(negedge clk);
      begin
         int en_seen = 0;
         for (int c = 0; c < 50; c++) begin
            if (en16_o) en_seen++;
            @(negedge clk);
         end
         check(en_seen == 0, "R1 no enable after reset", en_seen, 0);
      end

      // table-driven rate checks: R2 tick spacing, R3 enable count, R5, R8
      for (int v = 0; v < 7; v++) begin
         int p, cyc, en_cnt, tk_cnt, tk_bad, exp_en;
         p   = int'(VECS[v].dm1) + 1;
         cyc = int'(VECS[v].cyc);
         en_cnt = 0; tk_cnt = 0; tk_bad = 0;
         write_cfg(VECS[v].dm1, VECS[v].step, VECS[v].flt);
         check(flt_o == VECS[v].flt, "R8 filter field on flt_o", int'(flt_o), int'(VECS[v].flt));
         for (int c = 0; c < cyc; c++) begin
            if (en16_o) en_cnt++;
            if (tick_o) tk_cnt++;
            if (tick_o != (((c + 1) % p) == 0)) tk_bad++;
            @(negedge clk);
         end
         exp_en = (((cyc - 1) / p) * int'(VECS[v].step)) / 256;
         check(tk_bad == 0, "R2 tick positions", tk_bad, 0);
         check(tk_cnt == cyc / p, "R2 tick count", tk_cnt, cyc / p);
         check(en_cnt == exp_en, "R3 enable count", en_cnt, exp_en);
         if (VECS[v].step == 8'd0)
            check(en_cnt == 0, "R5 zero step silent", en_cnt, 0);
      end

      // R4: first enable one cycle after first carrying tick (P=3, step 64 -> cycle 12)
      begin
         int early = 0;
         write_cfg(3'd2, 8'd64, 8'h3C);
         for (int c = 0; c < 12; c++) begin
            if (en16_o) early++;
            if (c == 11) check(tick_o == 1'b1, "R2 tick at cycle 11", int'(tick_o), 1);
            @(negedge clk);
         end
         check(early == 0, "R4 no enable before cycle 12", early, 0);
         check(en16_o == 1'b1, "R4 enable at cycle 12", int'(en16_o), 1);
         @(negedge clk);
         check(en16_o == 1'b0, "R4 single-cycle pulse at 13", int'(en16_o), 0);
      end

      // R6: P=1, step 255
      begin
         int holes = 0;
         write_cfg(3'd0, 8'd255, 8'h00);
         check(en16_o == 1'b0, "R6 cycle 0 low", int'(en16_o), 0);
         @(negedge clk);
         check(en16_o == 1'b0, "R6 cycle 1 low", int'(en16_o), 0);
         @(negedge clk);
         for (int c = 2; c <= 256; c++) begin
            if (!en16_o) holes++;
            @(negedge clk);
         end
         check(holes == 0, "R6 cycles 2..256 high", holes, 0);
         check(en16_o == 1'b0, "R6 cycle 257 low", int'(en16_o), 0);
      end

      // R7: rewrite in mid-phase restarts from zero (P=3, step 128 -> first enable cycle 6)
      begin
         int early = 0;
         write_cfg(3'd2, 8'd128, 8'h44);
         repeat (4) @(negedge clk);
         write_cfg(3'd2, 8'd128, 8'h44);
         check(en16_o == 1'b0, "R7 enable cleared at cycle 0", int'(en16_o), 0);
         for (int c = 0; c < 6; c++) begin
            if (en16_o) early++;
            @(negedge clk);
         end
         check(early == 0, "R7 no enable before cycle 6", early, 0);
         check(en16_o == 1'b1, "R7 enable at cycle 6", int'(en16_o), 1);
      end

      // R1: reset in mid-run clears everything
      begin
         int en_seen = 0;
         write_cfg(3'd0, 8'd255, 8'h99);
         repeat (10) @(negedge clk);
         rst = 1'b1;
         @(negedge clk);
         check(en16_o == 1'b0, "R1 en after mid-run reset", int'(en16_o), 0);
         check(flt_o == 8'h00, "R1 flt after mid-run reset", int'(flt_o), 0);
         rst = 1'b0;
         for (int c = 0; c < 30; c++) begin
            if (en16_o) en_seen++;
            @(negedge clk);
         end
         check(en_seen == 0, "R1 quiet after mid-run reset", en_seen, 0);
      end

      finish_run();
   end

endmodule